// File: doc/BRIEF.md
# Memory-Map Configuration and Decode Unit

This block holds a small set of configuration registers on the processor's I/O bus and turns their contents into address-decode and pin-control signals. The registers cover the processor operating mode, the placement of the on-chip single-access RAM, the choice of signal on the read-strobe pin, the access mode of each of the two flash banks, and the clock-output disable.

Two combinational decoders classify addresses. The program-space decoder sorts each program address into one of three targets: on-chip RAM, one flash bank (either its array or its register window), or external memory. The data-space decoder sorts each data address into on-chip RAM or external memory. The operating-mode bit is taken from a board pin while reset is held and can be changed by software after that. Register reads are combinational from the I/O address. Register writes take effect on the clock edge that samples the write strobe.

Top module: `memmap_cfg_decode`

## Requirements
- R1: After reset, I/O reads return 0001h at FFE0h and at FFE1h, 0000h at FFE8h, and 0006h plus the boot-mode pin level (in bit 0) at FFE4h.
- R2: Mode register (FFE4h) bit 0 takes the level of `boot_mode_pin` while reset is held. A later write to it replaces that value: 1 selects microprocessor mode and 0 selects microcontroller mode.
- R3: Reserved bits read as zero and ignore writes. In FFE0h, FFE1h and FFE8h only bit 0 is implemented. In FFE4h only bits 15, 2, 1 and 0 are implemented. Any other I/O address reads 0000h, and a write to it changes no register.
- R4: Mode bit 1 maps the RAM into program space at 8000h–8FFFh. Mode bit 2 maps the RAM into data space at 0800h–17FFh. An address inside an enabled window asserts the RAM select for that space.
- R5: In microcontroller mode, program addresses 0000h–3FFFh belong to flash bank 0 and 4000h–7FFFh belong to bank 1. When bit 0 of the bank's access register (FFE0h for bank 0, FFE1h for bank 1) is 1, the array select for that bank is asserted. When it is 0, the register-window select for that bank is asserted.
- R6: In microprocessor mode, program addresses 0000h–7FFFh select external memory and never assert a flash select.
- R7: For each space, exactly one select is active at a time. The external select is asserted exactly when no on-chip target claims the address.
- R8: When mode bit 15 is 0, `rd_pin_n` follows `cpu_rd_n`. When it is 1, `rd_pin_n` is the inverse of `cpu_rw`.
- R9: `clkout_en` is the inverse of bit 0 of the clock register (FFE8h).
- R10: A write is applied at the rising clock edge that samples `io_wr` high, and it is visible on readback and on the decoders after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode_pin | input | 1 | Operating-mode pin level, sampled while in reset |
| io_addr | input | 16 | I/O register address |
| io_wdata | input | 16 | I/O write data |
| io_wr | input | 1 | I/O write strobe |
| io_rdata | output | 16 | I/O read data for io_addr |
| prog_addr | input | 16 | Program-space address to decode |
| data_addr | input | 16 | Data-space address to decode |
| prog_ram_sel | output | 1 | Program address hits on-chip RAM |
| prog_flash_arr_sel | output | 2 | Per-bank flash array select |
| prog_flash_reg_sel | output | 2 | Per-bank flash register-window select |
| prog_ext_sel | output | 1 | Program address goes to external memory |
| data_ram_sel | output | 1 | Data address hits on-chip RAM |
| data_ext_sel | output | 1 | Data address goes to external memory |
| cpu_rd_n | input | 1 | Core read strobe, active low |
| cpu_rw | input | 1 | Core read/write line, 1 for read |
| rd_pin_n | output | 1 | Signal driven to the read-strobe pin |
| clkout_en | output | 1 | Clock-output pin enable |

## Verification
The assertions check on every cycle that each space has exactly one select active, that a RAM select only occurs inside its window, and that flash selects only occur below 8000h. They also check the effect of single writes: microprocessor mode suppresses flash, and the clock and read-pin bits act on the cycle after they are written. Only the bench's sweeps show the full decode table, because they step through every combination of mode, RAM mapping and bank access with addresses placed on each window edge. The bench also covers the pin capture across two resets with different pin levels, and the reserved-bit and unmapped-address behaviour, which it checks by reading back over the I/O bus.

// File: rtl/memmap_pkg.sv
// Package: shared I/O addresses and bit positions of the configuration registers.
// Assumes a 16-bit I/O address bus and two flash banks.
package memmap_pkg;
    localparam int          IO_AW         = 16;
    localparam int          FLASH_BANKS   = 2;
    localparam logic [15:0] IO_FACC_BASE  = 16'hFFE0;
    localparam logic [15:0] IO_MODE       = 16'hFFE4;
    localparam logic [15:0] IO_CLKCTL     = 16'hFFE8;
    localparam int          MODE_MP_BIT   = 0;
    localparam int          MODE_PON_BIT  = 1;
    localparam int          MODE_DON_BIT  = 2;
    localparam int          MODE_FRD_BIT  = 15;
endpackage

// File: rtl/mm_window_match.sv
// Address window comparator: hit when BASE <= addr < BASE + WORDS.
// Assumes BASE + WORDS <= 2**AW. The compare uses one extra bit so that
// addresses below BASE wrap to large values and miss.
module mm_window_match #(
    parameter int AW    = 16,
    parameter int BASE  = 0,
    parameter int WORDS = 4096
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam logic [AW:0] LO   = (AW+1)'(BASE);
    localparam logic [AW:0] SPAN = (AW+1)'(WORDS);

    logic [AW:0] offset;

    // offset of the address from the window base, modulo 2**(AW+1)
    always_comb offset = {1'b0, addr} - LO;

    // inside the window when the offset is below the span
    always_comb hit = (offset < SPAN);
endmodule

// File: rtl/memmap_cfg_regs.sv
// Configuration register file on the I/O bus: flash access registers,
// the mode register and the clock register. Reads are combinational and
// writes apply on the clock edge. Reset is synchronous and active low.
// The mode bit follows the boot pin while reset is held.
module memmap_cfg_regs
    import memmap_pkg::*;
#(
    parameter int NB = FLASH_BANKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_mode_pin,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [15:0]      io_wdata,
    input  logic             io_wr,
    output logic [15:0]      io_rdata,
    output logic             mp_mode,
    output logic             ram_prog_en,
    output logic             ram_data_en,
    output logic             fast_rd,
    output logic [NB-1:0]    flash_array_mode,
    output logic             clk_off
);
    logic unused_wdata;
    assign unused_wdata = ^io_wdata[14:3];

    // mode register: pin capture in reset, software write afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mp_mode     <= boot_mode_pin;
            ram_prog_en <= 1'b1;
            ram_data_en <= 1'b1;
            fast_rd     <= 1'b0;
        end else if (io_wr && io_addr == IO_MODE) begin
            mp_mode     <= io_wdata[MODE_MP_BIT];
            ram_prog_en <= io_wdata[MODE_PON_BIT];
            ram_data_en <= io_wdata[MODE_DON_BIT];
            fast_rd     <= io_wdata[MODE_FRD_BIT];
        end
    end

    // clock register: output disable bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            clk_off <= 1'b0;
        else if (io_wr && io_addr == IO_CLKCTL)
            clk_off <= io_wdata[0];
    end

    // one access-mode flop per flash bank at consecutive I/O addresses
    for (genvar b = 0; b < NB; b++) begin : g_facc
        localparam logic [IO_AW-1:0] BANK_ADDR = IO_FACC_BASE + IO_AW'(b);
        always_ff @(posedge clk) begin
            if (!rst_n)
                flash_array_mode[b] <= 1'b1;
            else if (io_wr && io_addr == BANK_ADDR)
                flash_array_mode[b] <= io_wdata[0];
        end
    end

    // readback mux: reserved bits and unmapped addresses return zero
    always_comb begin
        io_rdata = '0;
        if (io_addr == IO_MODE) begin
            io_rdata[MODE_MP_BIT]  = mp_mode;
            io_rdata[MODE_PON_BIT] = ram_prog_en;
            io_rdata[MODE_DON_BIT] = ram_data_en;
            io_rdata[MODE_FRD_BIT] = fast_rd;
        end
        if (io_addr == IO_CLKCTL)
            io_rdata[0] = clk_off;
        for (int b = 0; b < NB; b++) begin
            if (io_addr == IO_FACC_BASE + IO_AW'(b))
                io_rdata[0] = flash_array_mode[b];
        end
    end
endmodule

// File: rtl/mm_pin_ctrl.sv
// Pin control: picks the read-strobe pin source and drives the clock-output
// enable. Purely combinational. Assumes cpu_rw is 1 for a read cycle.
module mm_pin_ctrl (
    input  logic fast_rd,
    input  logic clk_off,
    input  logic cpu_rd_n,
    input  logic cpu_rw,
    output logic rd_pin_n,
    output logic clkout_en
);
    // read pin carries the inverted read/write line when fast read is set
    always_comb rd_pin_n = fast_rd ? ~cpu_rw : cpu_rd_n;

    // clock output is active unless it is disabled
    always_comb clkout_en = ~clk_off;
endmodule

// File: rtl/memmap_cfg_decode.sv
// Top: configuration registers plus program and data address decoders.
// The program space holds a RAM window and NB flash banks from address 0.
// The data space holds a RAM window only.
// Assumes the windows do not overlap and the flash banks lie below the RAM window.
module memmap_cfg_decode
    import memmap_pkg::*;
#(
    parameter int AW          = 16,
    parameter int RAM_WORDS   = 4096,
    parameter int PRAM_BASE   = 'h8000,
    parameter int DRAM_BASE   = 'h0800,
    parameter int FBANK_WORDS = 'h4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_mode_pin,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [15:0]      io_wdata,
    input  logic             io_wr,
    output logic [15:0]      io_rdata,
    input  logic [AW-1:0]    prog_addr,
    input  logic [AW-1:0]    data_addr,
    output logic             prog_ram_sel,
    output logic [FLASH_BANKS-1:0] prog_flash_arr_sel,
    output logic [FLASH_BANKS-1:0] prog_flash_reg_sel,
    output logic             prog_ext_sel,
    output logic             data_ram_sel,
    output logic             data_ext_sel,
    input  logic             cpu_rd_n,
    input  logic             cpu_rw,
    output logic             rd_pin_n,
    output logic             clkout_en
);
    localparam int NB = FLASH_BANKS;

    logic          mp_mode, ram_prog_en, ram_data_en, fast_rd, clk_off;
    logic [NB-1:0] flash_array_mode;
    logic          pram_hit, dram_hit;
    logic [NB-1:0] bank_hit, bank_claim;

    memmap_cfg_regs #(.NB(NB)) regs_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .boot_mode_pin    (boot_mode_pin),
        .io_addr          (io_addr),
        .io_wdata         (io_wdata),
        .io_wr            (io_wr),
        .io_rdata         (io_rdata),
        .mp_mode          (mp_mode),
        .ram_prog_en      (ram_prog_en),
        .ram_data_en      (ram_data_en),
        .fast_rd          (fast_rd),
        .flash_array_mode (flash_array_mode),
        .clk_off          (clk_off)
    );

    mm_window_match #(.AW(AW), .BASE(PRAM_BASE), .WORDS(RAM_WORDS)) pram_win_i (
        .addr (prog_addr),
        .hit  (pram_hit)
    );

    mm_window_match #(.AW(AW), .BASE(DRAM_BASE), .WORDS(RAM_WORDS)) dram_win_i (
        .addr (data_addr),
        .hit  (dram_hit)
    );

    // one window per flash bank, stacked upward from program address 0
    for (genvar b = 0; b < NB; b++) begin : g_bank
        mm_window_match #(.AW(AW), .BASE(b * FBANK_WORDS), .WORDS(FBANK_WORDS)) win_i (
            .addr (prog_addr),
            .hit  (bank_hit[b])
        );
    end

    // flash claims the address only in microcontroller mode
    always_comb bank_claim = mp_mode ? '0 : bank_hit;

    // program-space select outputs
    always_comb begin
        prog_ram_sel       = ram_prog_en & pram_hit;
        prog_flash_arr_sel = bank_claim & flash_array_mode;
        prog_flash_reg_sel = bank_claim & ~flash_array_mode;
        prog_ext_sel       = ~(prog_ram_sel | (|bank_claim));
    end

    // data-space select outputs
    always_comb begin
        data_ram_sel = ram_data_en & dram_hit;
        data_ext_sel = ~data_ram_sel;
    end

    mm_pin_ctrl pins_i (
        .fast_rd   (fast_rd),
        .clk_off   (clk_off),
        .cpu_rd_n  (cpu_rd_n),
        .cpu_rw    (cpu_rw),
        .rd_pin_n  (rd_pin_n),
        .clkout_en (clkout_en)
    );
endmodule

// File: rtl/memmap_cfg_decode_chk.sv
// Checker: cycle-level properties of the decode unit, observed at its ports.
// Attached to every instance of the top through the bind below.
module memmap_cfg_decode_chk
    import memmap_pkg::*;
#(
    parameter int AW        = 16,
    parameter int RAM_WORDS = 4096,
    parameter int PRAM_BASE = 'h8000,
    parameter int DRAM_BASE = 'h0800
) (
    input logic             clk,
    input logic             rst_n,
    input logic             boot_mode_pin,
    input logic [IO_AW-1:0] io_addr,
    input logic [15:0]      io_wdata,
    input logic             io_wr,
    input logic [15:0]      io_rdata,
    input logic [AW-1:0]    prog_addr,
    input logic [AW-1:0]    data_addr,
    input logic             prog_ram_sel,
    input logic [FLASH_BANKS-1:0] prog_flash_arr_sel,
    input logic [FLASH_BANKS-1:0] prog_flash_reg_sel,
    input logic             prog_ext_sel,
    input logic             data_ram_sel,
    input logic             data_ext_sel,
    input logic             cpu_rd_n,
    input logic             cpu_rw,
    input logic             rd_pin_n,
    input logic             clkout_en
);
    localparam logic [AW:0] PLO = (AW+1)'(PRAM_BASE);
    localparam logic [AW:0] PHI = (AW+1)'(PRAM_BASE + RAM_WORDS);
    localparam logic [AW:0] DLO = (AW+1)'(DRAM_BASE);
    localparam logic [AW:0] DHI = (AW+1)'(DRAM_BASE + RAM_WORDS);

    logic unused_chk;
    assign unused_chk = ^{boot_mode_pin, io_rdata, cpu_rd_n};

    AST_PROG_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({prog_ram_sel, prog_flash_arr_sel, prog_flash_reg_sel, prog_ext_sel}) == 1); // R7
    AST_DATA_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({data_ram_sel, data_ext_sel}) == 1); // R7
    AST_PRAM_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ram_sel |-> ({1'b0, prog_addr} >= PLO && {1'b0, prog_addr} < PHI)); // R4
    AST_DRAM_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        data_ram_sel |-> ({1'b0, data_addr} >= DLO && {1'b0, data_addr} < DHI)); // R4
    AST_FLASH_BELOW_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (|{prog_flash_arr_sel, prog_flash_reg_sel}) |-> ({1'b0, prog_addr} < PLO)); // R5
    AST_MP_NO_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == IO_MODE && io_wdata[MODE_MP_BIT])
        |=> (prog_flash_arr_sel == '0 && prog_flash_reg_sel == '0)); // R6
    AST_FRD_SELECTS_RW: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == IO_MODE && io_wdata[MODE_FRD_BIT])
        |=> (rd_pin_n == !cpu_rw)); // R8
    AST_CLK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == IO_CLKCTL) |=> (clkout_en == !$past(io_wdata[0]))); // R9
endmodule

bind memmap_cfg_decode memmap_cfg_decode_chk chk_i (.*);

// File: tb/memmap_cfg_decode_tb_top.sv
// Bench: sweeps every mode/RAM/bank-access combination over program and
// data addresses placed on window edges, and compares against a model.
module memmap_cfg_decode_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_mode_pin = 1'b0;
    logic [15:0] io_addr = '0, io_wdata = '0;
    logic        io_wr = 1'b0;
    logic [15:0] io_rdata;
    logic [15:0] prog_addr = '0, data_addr = '0;
    logic        prog_ram_sel, prog_ext_sel, data_ram_sel, data_ext_sel;
    logic [1:0]  prog_flash_arr_sel, prog_flash_reg_sel;
    logic        cpu_rd_n = 1'b1, cpu_rw = 1'b1;
    logic        rd_pin_n, clkout_en;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    memmap_cfg_decode dut_i (.*);

    always #2 clk = ~clk;

    // watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic io_check(input string req, input logic [15:0] a, input logic [15:0] exp);
        io_addr = a; #1;
        chk(req, {16'h0, io_rdata}, {16'h0, exp});
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst_n = 1'b0; boot_mode_pin = pin;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; boot_mode_pin = ~pin;
        @(posedge clk); #1;
    endtask

    // model of program-space selects: {ram, arr[1:0], reg[1:0], ext}
    function automatic logic [5:0] exp_prog(input int a, input bit mp, input bit pon, input bit [1:0] fa);
        bit ram, fl;
        bit [1:0] arr, rg;
        ram = pon && a >= 'h8000 && a < 'h9000;
        fl  = !mp && a < 'h8000;
        arr = '0; rg = '0;
        if (fl) begin
            if (fa[a / 'h4000]) arr[a / 'h4000] = 1'b1;
            else                rg[a / 'h4000]  = 1'b1;
        end
        return {ram, arr, rg, !(ram || fl)};
    endfunction

    initial begin
        // R1 R2: reset values with the pin high, then low
        do_reset(1'b1);
        io_check("R1 facc0", 16'hFFE0, 16'h0001);
        io_check("R1 facc1", 16'hFFE1, 16'h0001);
        io_check("R1 clk",   16'hFFE8, 16'h0000);
        io_check("R2 mode pin=1", 16'hFFE4, 16'h0007);
        chk("R9 clkout at reset", {31'h0, clkout_en}, 32'h1);
        do_reset(1'b0);
        io_check("R2 mode pin=0", 16'hFFE4, 16'h0006);
        io_write(16'hFFE4, 16'h0007);
        io_check("R2 mode write mp", 16'hFFE4, 16'h0007);

        // R3 R10: reserved bits and unmapped addresses
        io_write(16'hFFE0, 16'hFFFE);
        io_check("R3 R10 facc0 bit0 cleared", 16'hFFE0, 16'h0000);
        io_check("R3 facc1 untouched", 16'hFFE1, 16'h0001);
        io_write(16'hFFE1, 16'hFFFF);
        io_check("R3 facc1 reserved", 16'hFFE1, 16'h0001);
        io_write(16'hFFE4, 16'hFFFF);
        io_check("R3 mode reserved", 16'hFFE4, 16'h8007);
        io_write(16'hFFE8, 16'hFFFF);
        io_check("R3 clk reserved", 16'hFFE8, 16'h0001);
        io_write(16'hFFE2, 16'hFFFF);
        io_write(16'hFFE5, 16'h0000);
        io_check("R3 unmapped FFE2 reads 0", 16'hFFE2, 16'h0000);
        io_check("R3 unmapped FFE5 reads 0", 16'hFFE5, 16'h0000);
        io_check("R3 facc0 after unmapped", 16'hFFE0, 16'h0000);
        io_check("R3 mode after unmapped", 16'hFFE4, 16'h8007);
        io_check("R3 clk after unmapped", 16'hFFE8, 16'h0001);

        // R8 R9: pin controls under both settings
        chk("R9 clkout off", {31'h0, clkout_en}, 32'h0);
        for (int f = 0; f < 2; f++) begin
            io_write(16'hFFE4, f[0] ? 16'h8006 : 16'h0006);
            for (int v = 0; v < 4; v++) begin
                cpu_rd_n = v[0]; cpu_rw = v[1]; #1;
                chk("R8 read pin", {31'h0, rd_pin_n},
                    {31'h0, f[0] ? ~v[1] : v[0]});
            end
        end
        io_write(16'hFFE8, 16'h0000);
        chk("R9 clkout on", {31'h0, clkout_en}, 32'h1);

        // R4 R5 R6 R7: full configuration sweep with edge-aligned addresses
        for (int mp = 0; mp < 2; mp++) begin
            for (int rm = 0; rm < 4; rm++) begin
                for (int fa = 0; fa < 4; fa++) begin
                    io_write(16'hFFE4, 16'((rm << 1) | mp));
                    io_write(16'hFFE0, 16'(fa & 1));
                    io_write(16'hFFE1, 16'((fa >> 1) & 1));
                    for (int i = 0; i < 256; i++) begin
                        int a;
                        a = i * 256 + ((i % 2) * 255);
                        prog_addr = 16'(a); data_addr = 16'(a); #1;
                        chk("R4 R5 R6 R7 prog decode",
                            {26'h0, prog_ram_sel, prog_flash_arr_sel, prog_flash_reg_sel, prog_ext_sel},
                            {26'h0, exp_prog(a, mp[0], rm[0], fa[1:0])});
                        chk("R4 R7 data decode",
                            {30'h0, data_ram_sel, data_ext_sel},
                            {30'h0, (rm[1] && a >= 'h800 && a < 'h1800) ? 2'b10 : 2'b01});
                    end
                end
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule